// File: doc/BRIEF.md
# Film Dot-Grid Payload Byte Extractor

This block turns one square grid of binary film dots into a stream of payload bytes. Dots arrive one per cycle in raster order on a valid/ready stream. A flag marks the first dot of each grid. The grid is 76 dots on each side. Two kinds of region carry no data: the four corner alignment squares, each 8 by 8 dots, and a 12 by 12 logo square at the centre. The block drops both kinds.

Every other dot belongs to a tile 2 dots wide and 4 dots tall, and each tile forms one byte. The block holds one band of four raster rows at a time. When the band is full it stops taking input and walks the 38 tiles of the band from left to right. It emits each tile that is kept and passes over each tile that is skipped. A full grid gives 672 bytes, and the last of them is flagged.

A grid that is cut short is detected when the next first-dot flag arrives at a position other than the origin. The block then raises a one-cycle error, drops the partial band and starts again from that dot.

Top module: `dgx_byte_extract`

## Requirements
- R1: While reset is held and after it is released, out_valid and code_err are low and in_ready is high.
- R2: A tile is dropped when it lies in a corner square (rows 0..7 or 68..75 combined with columns 0..7 or 68..75) or in the centre square (rows and columns 32..43). A complete grid yields exactly 672 bytes.
- R3: For the tile at tile row tr and tile column tc, byte bit k is the dot at grid row 4*tr + (k mod 4) and column 2*tc + (k div 4). Bit 0 is therefore the top dot of the left column, and bits 4..7 come from the right column.
- R4: Bytes leave in tile-row-major order: left to right within a band, bands from top to bottom.
- R5: out_last is high with the 672nd byte of a grid and with no other byte.
- R6: While out_valid is high and out_ready is low, out_valid, out_byte and out_last hold their values.
- R7: From the acceptance of the last dot of a band until every tile of that band has been passed, in_ready is low and no dot is taken.
- R8: If a dot flagged with in_first is accepted at a position other than the grid origin, code_err is high for exactly the next cycle. That dot becomes row 0, column 0, and the byte count restarts.
- R9: A dot flagged with in_first that is accepted at the grid origin raises no error.
- R10: Each tile position of a band takes one drain cycle, whether it is skipped or handed over. For the first band, whose leftmost four tiles are markers, out_valid first rises on the fourth rising edge after the edge that accepted the band's last dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A dot is offered |
| in_ready | output | 1 | The block can take a dot |
| in_dot | input | 1 | Dot value |
| in_first | input | 1 | The offered dot is the first of a grid |
| out_valid | output | 1 | A payload byte is offered |
| out_ready | input | 1 | The consumer takes the byte |
| out_byte | output | 8 | Payload byte |
| out_last | output | 1 | The offered byte is the final byte of the grid |
| code_err | output | 1 | One-cycle pulse: the previous grid ended early |

## Verification
A dot is taken on the rising edge when in_valid and in_ready are both high. The byte for a band becomes visible only after the edge that takes the band's last dot. Each tile position after that costs one edge, so the first byte of the top band appears four edges later. code_err comes from a register and is visible right after the edge that took the offending dot. The bench drives inputs and samples outputs on falling edges. It counts falling edges after the accepting edge to check the four-edge delay and the error pulse, and it sets out_ready at the same falling edge at which it records a transfer.

// File: rtl/dgx_pkg.sv
package dgx_pkg;
   typedef enum logic {
      PH_FILL  = 1'b0,
      PH_DRAIN = 1'b1
   } dgx_phase_e;
endpackage

// File: rtl/dgx_zone_map.sv
module dgx_zone_map #(
   parameter int unsigned GRID   = 76,
   parameter int unsigned MARK   = 8,
   parameter int unsigned LOGO   = 12,
   parameter int unsigned TILE_W = 2,
   parameter int unsigned TILE_H = 4,
   parameter int unsigned TR_W   = 5,
   parameter int unsigned TC_W   = 6
) (
   input  logic [TR_W-1:0] trow,
   input  logic [TC_W-1:0] tcol,
   output logic            keep
);
   localparam int unsigned LOGO_LO = (GRID - LOGO) / 2;
   localparam int unsigned LOGO_HI = LOGO_LO + LOGO;
   localparam int unsigned FAR_EDGE = GRID - MARK;

   int unsigned r0;
   int unsigned c0;
   logic        row_edge, col_edge, row_mid, col_mid;

   always_comb begin
      r0       = int'(trow) * TILE_H;
      c0       = int'(tcol) * TILE_W;
      row_edge = (r0 < MARK) || (r0 >= FAR_EDGE);
      col_edge = (c0 < MARK) || (c0 >= FAR_EDGE);
      row_mid  = (r0 >= LOGO_LO) && (r0 < LOGO_HI);
      col_mid  = (c0 >= LOGO_LO) && (c0 < LOGO_HI);
      keep     = !((row_edge && col_edge) || (row_mid && col_mid));
   end
endmodule

// File: rtl/dgx_tile_buf.sv
module dgx_tile_buf #(
   parameter int unsigned GRID   = 76,
   parameter int unsigned TILE_W = 2,
   parameter int unsigned TILE_H = 4,
   parameter int unsigned COL_W  = 7,
   parameter int unsigned RS_W   = 2,
   parameter int unsigned TC_W   = 6
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [RS_W-1:0]          wr_row,
   input  logic [COL_W-1:0]         wr_col,
   input  logic                     wr_dot,
   input  logic [TC_W-1:0]          rd_tcol,
   output logic [TILE_W*TILE_H-1:0] rd_byte
);
   localparam int unsigned BW = TILE_W * TILE_H;

   logic [GRID-1:0] band_q [TILE_H];

   always_ff @(posedge clk) begin
      if (wr_en) band_q[wr_row][wr_col] <= wr_dot;
   end

   for (genvar k = 0; k < BW; k++) begin : g_bit
      localparam int unsigned RI = k % TILE_H;
      localparam int unsigned CI = k / TILE_H;
      logic [COL_W-1:0] cidx;
      assign cidx       = COL_W'(rd_tcol) * COL_W'(TILE_W) + COL_W'(CI);
      assign rd_byte[k] = band_q[RI][cidx];
   end
endmodule

// File: rtl/dgx_byte_extract.sv
module dgx_byte_extract #(
   parameter int unsigned GRID   = 76,
   parameter int unsigned MARK   = 8,
   parameter int unsigned LOGO   = 12,
   parameter int unsigned TILE_W = 2,
   parameter int unsigned TILE_H = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic                     in_dot,
   input  logic                     in_first,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [TILE_W*TILE_H-1:0] out_byte,
   output logic                     out_last,
   output logic                     code_err
);
   import dgx_pkg::*;

   localparam int unsigned BW     = TILE_W * TILE_H;
   localparam int unsigned TCOLS  = GRID / TILE_W;
   localparam int unsigned TROWS  = GRID / TILE_H;
   localparam int unsigned NBYTES = (GRID * GRID - 4 * MARK * MARK - LOGO * LOGO) / BW;
   localparam int unsigned COL_W  = $clog2(GRID);
   localparam int unsigned TC_W   = $clog2(TCOLS);
   localparam int unsigned TR_W   = $clog2(TROWS);
   localparam int unsigned RS_W   = $clog2(TILE_H);
   localparam int unsigned BC_W   = $clog2(NBYTES);
   localparam int unsigned LOGO_LO = (GRID - LOGO) / 2;

   localparam logic [COL_W-1:0] COL_LAST  = COL_W'(GRID - 1);
   localparam logic [RS_W-1:0]  SUB_LAST  = RS_W'(TILE_H - 1);
   localparam logic [TC_W-1:0]  TCOL_LAST = TC_W'(TCOLS - 1);
   localparam logic [TR_W-1:0]  TROW_LAST = TR_W'(TROWS - 1);
   localparam logic [BC_W-1:0]  BC_LAST   = BC_W'(NBYTES - 1);

   if (TILE_H < 2 || TILE_W < 1) begin : g_bad_tile
      $error("tile must be at least 1 wide and 2 tall");
   end
   if ((GRID % TILE_W) != 0 || (GRID % TILE_H) != 0) begin : g_bad_grid
      $error("grid side must be a whole number of tiles");
   end
   if ((MARK % TILE_W) != 0 || (MARK % TILE_H) != 0) begin : g_bad_mark
      $error("corner squares must fall on tile boundaries");
   end
   if (((GRID - LOGO) % 2) != 0 || (LOGO_LO % TILE_W) != 0 || (LOGO_LO % TILE_H) != 0 ||
       (LOGO % TILE_W) != 0 || (LOGO % TILE_H) != 0) begin : g_bad_logo
      $error("centre square must be centred and tile aligned");
   end
   if ((1 << RS_W) != TILE_H) begin : g_bad_pow2
      $error("tile height must be a power of two");
   end

   dgx_phase_e        phase_q;
   logic [COL_W-1:0]  col_q;
   logic [RS_W-1:0]   sub_q;
   logic [TR_W-1:0]   trow_q;
   logic [TC_W-1:0]   tcol_q;
   logic [BC_W-1:0]   bcnt_q;
   logic              err_q;

   logic              acc, at_origin, keep, step;
   logic [COL_W-1:0]  pos_col;
   logic [RS_W-1:0]   pos_sub;
   logic [TR_W-1:0]   pos_trow;

   assign in_ready  = (phase_q == PH_FILL);
   assign acc       = in_valid && in_ready;
   assign at_origin = (col_q == '0) && (sub_q == '0) && (trow_q == '0);
   assign pos_col   = in_first ? '0 : col_q;
   assign pos_sub   = in_first ? '0 : sub_q;
   assign pos_trow  = in_first ? '0 : trow_q;

   dgx_zone_map #(
      .GRID(GRID), .MARK(MARK), .LOGO(LOGO),
      .TILE_W(TILE_W), .TILE_H(TILE_H), .TR_W(TR_W), .TC_W(TC_W)
   ) zone_i (
      .trow(trow_q),
      .tcol(tcol_q),
      .keep(keep)
   );

   dgx_tile_buf #(
      .GRID(GRID), .TILE_W(TILE_W), .TILE_H(TILE_H),
      .COL_W(COL_W), .RS_W(RS_W), .TC_W(TC_W)
   ) buf_i (
      .clk(clk),
      .wr_en(acc),
      .wr_row(pos_sub),
      .wr_col(pos_col),
      .wr_dot(in_dot),
      .rd_tcol(tcol_q),
      .rd_byte(out_byte)
   );

   assign out_valid = (phase_q == PH_DRAIN) && keep;
   assign out_last  = out_valid && (bcnt_q == BC_LAST);
   assign step      = keep ? out_ready : 1'b1;
   assign code_err  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FILL;
         col_q   <= '0;
         sub_q   <= '0;
         trow_q  <= '0;
         tcol_q  <= '0;
         bcnt_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= acc && in_first && !at_origin;
         if (acc) begin
            if (in_first) bcnt_q <= '0;
            trow_q <= pos_trow;
            if (pos_col == COL_LAST) begin
               col_q <= '0;
               if (pos_sub == SUB_LAST) begin
                  sub_q   <= '0;
                  tcol_q  <= '0;
                  phase_q <= PH_DRAIN;
               end else begin
                  sub_q <= pos_sub + 1'b1;
               end
            end else begin
               col_q <= pos_col + 1'b1;
               sub_q <= pos_sub;
            end
         end else if (phase_q == PH_DRAIN && step) begin
            if (keep) bcnt_q <= (bcnt_q == BC_LAST) ? '0 : bcnt_q + 1'b1;
            if (tcol_q == TCOL_LAST) begin
               phase_q <= PH_FILL;
               trow_q  <= (trow_q == TROW_LAST) ? '0 : trow_q + 1'b1;
            end else begin
               tcol_q <= tcol_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dgx_byte_extract_chk.sv
module dgx_byte_extract_chk #(
   parameter int unsigned BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          in_first,
   input logic          out_valid,
   input logic          out_ready,
   input logic [BW-1:0] out_byte,
   input logic          out_last,
   input logic          code_err
);
   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (!out_valid && !code_err && in_ready);
      end
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

   assert_no_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(code_err) |-> $past(in_valid && in_ready && in_first));

   assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
endmodule

bind dgx_byte_extract dgx_byte_extract_chk #(.BW(TILE_W*TILE_H)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_first(in_first), .out_valid(out_valid), .out_ready(out_ready),
   .out_byte(out_byte), .out_last(out_last), .code_err(code_err)
);

// File: tb/dgx_byte_extract_tb.sv
module dgx_byte_extract_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int G = 76;
   localparam int NB = 672;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_dot = 1'b0, in_first = 1'b0;
   logic in_ready, out_valid, out_last, code_err;
   logic out_ready = 1'b0;
   logic [7:0] out_byte;

   int n_checks = 0, n_errors = 0;
   int n_got = 0, n_err_pulse = 0, rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [7:0] got_b [0:4095];
   bit         got_l [0:4095];
   logic [7:0] exp_b [0:NB-1];

   always #(CLK_PERIOD/2) clk = ~clk;

   dgx_byte_extract dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_dot(in_dot), .in_first(in_first), .out_valid(out_valid),
      .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last),
      .code_err(code_err)
   );

   always @(negedge clk) begin
      if (rdy_mode == 0) out_ready = 1'b1;
      else if (rdy_mode == 1) out_ready = lfsr[0] | lfsr[3];
      else out_ready = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (out_valid && out_ready && n_got < 4096) begin
         got_b[n_got] = out_byte;
         got_l[n_got] = out_last;
         n_got++;
      end
      if (code_err) n_err_pulse++;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit dotv(input int seed, input int r, input int c);
      return ((r * 31 + c * 17 + (r * c) % 11 + seed * 7) % 5) < 2;
   endfunction

   function automatic bit kept(input int tr, input int tc);
      int r0 = tr * 4;
      int c0 = tc * 2;
      bit corner = (r0 < 8 || r0 >= 68) && (c0 < 8 || c0 >= 68);
      bit logo = (r0 >= 32 && r0 < 44) && (c0 >= 32 && c0 < 44);
      return !(corner || logo);
   endfunction

   task automatic build_exp(input int seed);
      int idx = 0;
      for (int tr = 0; tr < 19; tr++)
         for (int tc = 0; tc < 38; tc++)
            if (kept(tr, tc)) begin
               for (int k = 0; k < 8; k++)
                  exp_b[idx][k] = dotv(seed, tr * 4 + k % 4, tc * 2 + k / 4);
               idx++;
            end
   endtask

   task automatic send(input bit d, input bit f);
      bit took;
      in_dot = d; in_first = f; in_valid = 1'b1;
      do begin
         took = in_ready;
         @(negedge clk);
      end while (!took);
      in_valid = 1'b0; in_first = 1'b0;
   endtask

   task automatic send_span(input int seed, input int from, input int upto);
      for (int i = from; i < upto; i++) send(dotv(seed, i / G, i % G), i == 0);
   endtask

   task automatic wait_bytes(input int target);
      int guard = 0;
      while (n_got < target && guard < 4000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic verify(input int base, input int cnt, input string what);
      for (int i = 0; i < cnt; i++) begin
         // R3 packing, R4 order
         check(got_b[base + i] === exp_b[i], $sformatf("R3/R4 %s byte %0d", what, i),
               int'(got_b[base + i]), int'(exp_b[i]));
         // R5 last flag
         check(got_l[base + i] == (i == NB - 1), $sformatf("R5 %s last at %0d", what, i),
               int'(got_l[base + i]), int'(i == NB - 1));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      check(code_err == 1'b0, "R1 code_err in reset", int'(code_err), 0);
      check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle after reset",
            int'({out_valid, in_ready}), 1);
   endtask

   task automatic t_full(input int seed, input int mode, input string what);
      int base = n_got;
      int e0 = n_err_pulse;
      rdy_mode = mode;
      build_exp(seed);
      send_span(seed, 0, G * G);
      wait_bytes(base + NB);
      repeat (60) @(negedge clk);
      check(n_got - base == NB, {"R2 byte count ", what}, n_got - base, NB);
      check(n_err_pulse == e0, {"R9 no error on aligned first ", what}, n_err_pulse - e0, 0);
      verify(base, NB, what);
   endtask

   task automatic t_stall();
      int base = n_got;
      rdy_mode = 2;
      build_exp(3);
      send_span(3, 0, G * 4);
      check(out_valid == 1'b0, "R10 no byte at edge 0", int'(out_valid), 0);
      for (int j = 1; j <= 4; j++) begin
         @(negedge clk);
         check(out_valid == (j == 4), $sformatf("R10 out_valid after %0d edges", j),
               int'(out_valid), int'(j == 4));
      end
      repeat (20) @(negedge clk);
      check(out_valid == 1'b1, "R6 byte held", int'(out_valid), 1);
      check(out_byte == exp_b[0], "R6 held byte value", int'(out_byte), int'(exp_b[0]));
      check(in_ready == 1'b0, "R7 input blocked during drain", int'(in_ready), 0);
      check(n_got == base, "R7 nothing taken while stalled", n_got - base, 0);
      rdy_mode = 0;
      send_span(3, G * 4, G * G);
      wait_bytes(base + NB);
      repeat (60) @(negedge clk);
      check(n_got - base == NB, "R2 byte count stall", n_got - base, NB);
      verify(base, NB, "stall");
   endtask

   task automatic t_early();
      int base = n_got;
      int e0 = n_err_pulse;
      rdy_mode = 0;
      build_exp(4);
      send_span(4, 0, G * 4 + 10);
      repeat (50) @(negedge clk);
      check(n_got - base == 30, "R7 partial band bytes", n_got - base, 30);
      for (int i = 0; i < 30; i++)
         check(got_b[base + i] === exp_b[i], $sformatf("R3 partial byte %0d", i),
               int'(got_b[base + i]), int'(exp_b[i]));
      check(code_err == 1'b0, "R8 no error before restart", int'(code_err), 0);
      base = n_got;
      build_exp(5);
      send(dotv(5, 0, 0), 1'b1);
      check(code_err == 1'b1, "R8 error pulse after restart", int'(code_err), 1);
      send_span(5, 1, G * G);
      check(code_err == 1'b0, "R8 error cleared", int'(code_err), 0);
      wait_bytes(base + NB);
      repeat (60) @(negedge clk);
      check(n_err_pulse - e0 == 1, "R8 single error pulse", n_err_pulse - e0, 1);
      check(n_got - base == NB, "R8 byte count restarted", n_got - base, NB);
      verify(base, NB, "restart");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_full(1, 0, "clean");
      t_full(2, 1, "backpressure");
      t_stall();
      t_early();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule